// File: doc/BRIEF.md
# Two-Thread Partitioned Reorder Buffer

This block tracks in-flight operations for an out-of-order core that runs two hardware threads. A thread claims an entry at dispatch and receives its index. A writeback unit later marks that index complete. Each thread retires its own entries strictly in the order they were claimed, at most one per cycle. A retire happens in the same cycle that the oldest entry of the thread is seen complete.

Storage is split statically. While both threads are active, each thread owns a fixed half of the entries, and neither thread's allocations can reach the other half. This means a thread that stalls cannot starve its sibling. When only one thread is active, that thread may use the whole array. The active-thread mask is requested on an input and is taken up only at a moment when the buffer holds nothing. A per-thread flush discards one thread's entries and leaves the other thread untouched.

Top module: `smt_rob`

## Requirements
- R1: With both threads active (mask 2'b11), thread 0 is given indices 0 to DEPTH/2-1 and thread 1 is given DEPTH/2 to DEPTH-1. Within its region a thread is given indices in ascending order, wrapping from the top of the region to its bottom.
- R2: With only one thread active (mask 2'b01 or 2'b10), that thread is given indices 0 to DEPTH-1 in ascending order, wrapping from DEPTH-1 to 0.
- R3: `full[t]` is 1 when thread t's region holds as many live entries as the region has slots. An allocation request while full creates no entry.
- R4: A thread retires its oldest live entry when that entry has been completed. It retires at most one entry per cycle and never retires out of allocation order. `ret_valid[t]` and `ret_idx` show the retire combinationally in the cycle it takes effect.
- R5: A completion whose index names no live entry has no effect. In particular, an entry allocated later at that index does not retire until it is completed itself.
- R6: `flush[t]` discards all of thread t's entries and returns its allocation point to the bottom of its region in the next cycle. The same cycle's allocation and retire for that thread are suppressed. The other thread's entries, order and completions are not affected.
- R7: `act` takes the value of `act_req` only at a clock edge where both threads hold no entries and no allocation is accepted. At that edge both allocation points restart at the bottom of their regions under the new mask. At all other times `act` holds.
- R8: A thread whose bit in `act` is 0 has `full` at 1, and its allocation requests are ignored.
- R9: After reset `act` is 2'b11, both threads are empty, `full` is 0 and no retire is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_req | input | 2 | Requested active-thread mask, one bit per thread |
| alloc_valid | input | 1 | Allocation request |
| alloc_tid | input | 1 | Thread making the allocation request |
| alloc_idx | output | IW | Index given to the request when accepted |
| cmp_valid | input | 1 | Completion strobe |
| cmp_idx | input | IW | Index being completed |
| flush | input | 2 | Per-thread discard of all entries |
| full | output | 2 | Per-thread no-free-slot flag |
| ret_valid | output | 2 | Per-thread retire this cycle |
| ret_idx0 | output | IW | Index retired by thread 0 |
| ret_idx1 | output | IW | Index retired by thread 1 |
| act | output | 2 | Current active-thread mask |

## Verification
The bench fills thread 0's half to the limit while thread 1 keeps allocating. A design that let one half spill into the other would hand thread 1 a low index or let thread 0 exceed 64 entries. Completions arrive in reverse age order, and a completion is aimed at a free slot that is later reused. Wrong designs would retire out of order, or retire the reused slot before its own completion. A mode change is requested while entries are live and then again after both threads are flushed. The bench checks that the lone thread then reaches all 128 indices while the idle thread reads full. Thread 1 is pushed past the top of its half to exercise the wrap back to the middle of the array rather than to zero.

// File: rtl/smt_rob.sv
module smt_rob #(
  parameter int DEPTH = 128,
  localparam int HALF = DEPTH / 2,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    act_req,
  input  logic          alloc_valid,
  input  logic          alloc_tid,
  output logic [IW-1:0] alloc_idx,
  input  logic          cmp_valid,
  input  logic [IW-1:0] cmp_idx,
  input  logic [1:0]    flush,
  output logic [1:0]    full,
  output logic [1:0]    ret_valid,
  output logic [IW-1:0] ret_idx0,
  output logic [IW-1:0] ret_idx1,
  output logic [1:0]    act
);

  logic [1:0]       act_q;
  logic [IW-1:0]    hd [2];
  logic [IW-1:0]    tl [2];
  logic [CW-1:0]    cnt [2];
  logic [DEPTH-1:0] vld, dn, own;

  logic [1:0]          acc;
  logic [1:0][IW-1:0]  bs, nbs, tl_n, hd_n;

  wire          dual  = &act_q;
  wire [CW-1:0] lim   = dual ? CW'(HALF) : CW'(DEPTH);
  wire          empty = (cnt[0] == '0) && (cnt[1] == '0);
  wire          sw    = empty && !(|acc);

  for (genvar g = 0; g < 2; g++) begin : g_thr
    wire [IW-1:0] last = bs[g] + IW'(lim - CW'(1));
    assign bs[g]        = (dual && g == 1) ? IW'(HALF) : '0;
    assign nbs[g]       = ((&act_req) && g == 1) ? IW'(HALF) : '0;
    assign full[g]      = !act_q[g] || (cnt[g] == lim);
    assign acc[g]       = alloc_valid && (alloc_tid == 1'(g)) && !full[g] && !flush[g];
    assign ret_valid[g] = (cnt[g] != '0) && dn[hd[g]] && !flush[g];
    assign tl_n[g]      = (tl[g] == last) ? bs[g] : tl[g] + IW'(1);
    assign hd_n[g]      = (hd[g] == last) ? bs[g] : hd[g] + IW'(1);
  end

  assign alloc_idx = tl[alloc_tid];
  assign ret_idx0  = hd[0];
  assign ret_idx1  = hd[1];
  assign act       = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 2'b11;
      hd[0] <= '0;
      tl[0] <= '0;
      hd[1] <= IW'(HALF);
      tl[1] <= IW'(HALF);
      cnt[0] <= '0;
      cnt[1] <= '0;
      vld <= '0;
      dn  <= '0;
      own <= '0;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (flush[t]) begin
          hd[t]  <= bs[t];
          tl[t]  <= bs[t];
          cnt[t] <= '0;
        end else begin
          if (acc[t]) tl[t] <= tl_n[t];
          if (ret_valid[t]) hd[t] <= hd_n[t];
          cnt[t] <= cnt[t] + CW'(acc[t]) - CW'(ret_valid[t]);
        end
      end
      if (sw) begin
        act_q <= act_req;
        for (int t = 0; t < 2; t++) begin
          hd[t] <= nbs[t];
          tl[t] <= nbs[t];
        end
      end
      if (cmp_valid && vld[cmp_idx]) dn[cmp_idx] <= 1'b1;
      if (|acc) begin
        vld[alloc_idx] <= 1'b1;
        dn[alloc_idx]  <= 1'b0;
        own[alloc_idx] <= alloc_tid;
      end
      for (int t = 0; t < 2; t++) begin
        if (ret_valid[t]) begin
          vld[hd[t]] <= 1'b0;
          dn[hd[t]]  <= 1'b0;
        end
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (vld[i] && flush[own[i]]) begin
          vld[i] <= 1'b0;
          dn[i]  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/smt_rob_chk.sv
module smt_rob_chk #(
  parameter int DEPTH = 128,
  localparam int HALF = DEPTH / 2,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    act,
  input logic          alloc_valid,
  input logic          alloc_tid,
  input logic [IW-1:0] alloc_idx,
  input logic [1:0]    full,
  input logic [1:0]    flush,
  input logic [1:0]    ret_valid,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1
);

  a_r1_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b11 && alloc_valid && !alloc_tid && !full[0]) |-> alloc_idx < IW'(HALF));

  a_r1_high_half: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b11 && alloc_valid && alloc_tid && !full[1]) |-> alloc_idx >= IW'(HALF));

  a_r1_share_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b11) |-> (cnt0 <= CW'(HALF) && cnt1 <= CW'(HALF)));

  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_tid && full[0] && !ret_valid[0] && !flush[0]) |=> cnt0 == $past(cnt0));

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush[1] |=> cnt1 == '0);

  a_r6_flush_spares: assert property (@(posedge clk) disable iff (!rst_n)
    (flush[0] && !flush[1] && !alloc_valid && !ret_valid[1]) |=> $stable(cnt1));

  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 != '0 || cnt1 != '0) |=> $stable(act));

  a_r8_idle_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!act[0] |-> full[0]) and (!act[1] |-> full[1]));

endmodule

bind smt_rob smt_rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .act(act), .alloc_valid(alloc_valid),
  .alloc_tid(alloc_tid), .alloc_idx(alloc_idx), .full(full), .flush(flush),
  .ret_valid(ret_valid), .cnt0(cnt[0]), .cnt1(cnt[1])
);

// File: tb/sim_smt_rob.sv
module sim_smt_rob;
  localparam int DEPTH = 128;
  localparam int IW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic [1:0] act_req = 2'b11;
  logic alloc_valid = 0, alloc_tid = 0, cmp_valid = 0;
  logic [IW-1:0] cmp_idx = '0;
  logic [1:0] flush = '0;
  logic [IW-1:0] alloc_idx, ret_idx0, ret_idx1;
  logic [1:0] full, ret_valid, act;

  always #2.5 clk = ~clk;

  smt_rob #(.DEPTH(DEPTH)) u0 (
    .clk, .rst_n, .act_req, .alloc_valid, .alloc_tid, .alloc_idx,
    .cmp_valid, .cmp_idx, .flush, .full, .ret_valid, .ret_idx0, .ret_idx1, .act
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  int q [2][$];
  bit mv [DEPTH];
  bit md [DEPTH];
  bit [1:0] mact = 2'b11;
  int mtl [2] = '{0, DEPTH / 2};

  function automatic int mlim(bit [1:0] a);
    return (a == 2'b11) ? DEPTH / 2 : DEPTH;
  endfunction
  function automatic int mbase(bit [1:0] a, int t);
    return (a == 2'b11 && t == 1) ? DEPTH / 2 : 0;
  endfunction
  function automatic bit efull(int t);
    return !mact[t] || q[t].size() == mlim(mact);
  endfunction
  function automatic bit erv(int t);
    return q[t].size() != 0 && md[q[t][0]] && !flush[t];
  endfunction

  task automatic chk(bit ok, string req, string what, int a, int e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  task automatic step();
    bit acc, sw;
    bit [1:0] rv;
    int idx;
    #1;
    chk(act == mact, "R7", "act", int'(act), int'(mact));
    for (int t = 0; t < 2; t++) begin
      chk(full[t] == efull(t), mact[t] ? "R3" : "R8", "full", int'(full[t]), int'(efull(t)));
      chk(ret_valid[t] == erv(t), "R4", "ret_valid", int'(ret_valid[t]), int'(erv(t)));
      if (erv(t))
        chk(int'(t ? ret_idx1 : ret_idx0) == q[t][0], "R4", "ret_idx",
            int'(t ? ret_idx1 : ret_idx0), q[t][0]);
    end
    acc = alloc_valid && !efull(int'(alloc_tid)) && !flush[alloc_tid];
    idx = mtl[alloc_tid];
    if (acc)
      chk(int'(alloc_idx) == idx, mact == 2'b11 ? "R1" : "R2", "alloc_idx", int'(alloc_idx), idx);
    rv[0] = erv(0);
    rv[1] = erv(1);
    sw = q[0].size() == 0 && q[1].size() == 0 && !acc;
    @(posedge clk);
    if (cmp_valid && mv[cmp_idx]) md[cmp_idx] = 1;
    for (int t = 0; t < 2; t++) begin
      if (flush[t]) begin
        foreach (q[t][k]) begin mv[q[t][k]] = 0; md[q[t][k]] = 0; end
        q[t].delete();
        mtl[t] = mbase(mact, t);
      end else if (rv[t]) begin
        mv[q[t][0]] = 0; md[q[t][0]] = 0;
        void'(q[t].pop_front());
      end
    end
    if (acc) begin
      int t = int'(alloc_tid);
      q[t].push_back(idx);
      mv[idx] = 1; md[idx] = 0;
      mtl[t] = (idx == mbase(mact, t) + mlim(mact) - 1) ? mbase(mact, t) : idx + 1;
    end
    if (sw) begin
      mact = act_req;
      mtl[0] = mbase(mact, 0);
      mtl[1] = mbase(mact, 1);
    end
    @(negedge clk);
    alloc_valid = 0; cmp_valid = 0; flush = '0;
  endtask

  task automatic alloc(int t, int n);
    repeat (n) begin alloc_valid = 1; alloc_tid = t[0]; step(); end
  endtask
  task automatic comp(int idx);
    cmp_valid = 1; cmp_idx = IW'(idx); step();
  endtask
  task automatic idle(int n);
    repeat (n) step();
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    if (!done_flag) $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int snap [$];
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    #1;
    chk(act == 2'b11, "R9", "act after reset", int'(act), 3);
    chk(full == 2'b00, "R9", "full after reset", int'(full), 0);
    chk(ret_valid == 2'b00, "R9", "ret_valid after reset", int'(ret_valid), 0);
    @(negedge clk);

    // R1, R4: both threads, completions in reverse age order
    alloc(0, 3);
    alloc(1, 3);
    comp(q[0][2]); comp(q[0][1]); comp(q[0][0]);
    idle(4);
    snap = q[1];
    foreach (snap[k]) comp(snap[k]);
    idle(3);

    // R3, R1: fill thread 0's half, thread 1 still allocates
    alloc(0, 66);
    alloc(1, 3);
    alloc(0, 2);

    // R7: mode request ignored while entries live
    act_req = 2'b01;
    idle(3);

    // R6: flush thread 0 leaves thread 1 intact
    flush = 2'b01; alloc_valid = 1; alloc_tid = 0; step();
    idle(2);
    comp(q[1][0]);
    idle(2);

    // R5: completion of a free slot is ignored on later reuse
    comp(0);
    alloc(0, 1);
    idle(4);
    comp(q[0][0]);
    idle(2);

    // R7, R2, R8: drain and switch to thread 0 alone
    flush = 2'b11; step();
    idle(2);
    alloc(0, 130);
    alloc(1, 2);
    for (int k = 0; k < 5; k++) comp(q[0][k]);
    idle(3);

    // R2: thread 1 alone starts from index 0
    act_req = 2'b10;
    flush = 2'b01; step();
    idle(2);
    alloc(1, 4);
    alloc(0, 1);
    snap = q[1];
    foreach (snap[k]) comp(snap[k]);
    idle(3);

    // R1 wrap: thread 1 passes the top of its half
    act_req = 2'b11;
    idle(2);
    for (int k = 0; k < 70; k++) begin
      alloc(1, 1);
      comp(q[1][0]);
    end
    idle(3);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule